// File: doc/BRIEF.md
# Dual-Half Timer Value Register

This block is a general-purpose timer built from two halves, A and B. Each half normally runs as a 24-bit down counter. Its low 16 bits are the main counter and its upper 8 bits are a prescaler that extends it. A configuration bit joins the two halves into a single 32-bit counter. Software reaches the timer through a simple word-addressed register bus.

Reads are combinational. Writes take effect at the clock edge where the write strobe is high. The counters count down and reload when they reach zero, and each reload raises a sticky timeout flag. Each half can also count edges on its own capture input, or latch its running count when such an edge arrives.

Register offsets on the bus:
- 0x00: control.
- 0x04: A value.
- 0x08: B value.
- 0x0C: A reload/capture.
- 0x10: B reload/capture.
- 0x14: status.

Control bits:
- bit 0: enable A.
- bit 1: enable B.
- bit 2: 32-bit join.
- bits 4:3: mode of A.
- bits 6:5: mode of B.

Mode codes are 0 for periodic, 1 for edge-count, 2 for edge-time, and 3 behaves as periodic.

Top module: `tmr_dual_value`

## Requirements
- R1: After reset both value registers read 0x00FFFFFF and both timeout outputs are 0. With the 32-bit join set (control 0x04) and nothing counting, the A value register reads 0xFFFFFFFF.
- R2: In 16-bit operation a value register holds the counter in bits 15:0 and the prescaler in bits 23:16, and bits 31:24 read as zero. A decrement borrows from the counter into the prescaler, so 0x010002 becomes 0x00FFFF after three counts.
- R3: Data written to a value register is loaded into that half's count at the clock edge after the write edge. One cycle after the write, the old count is still visible.
- R4: When a half is enabled in periodic mode, its value falls by one every clock. When the half is disabled, its value holds.
- R5: A count stepping from zero loads the half's reload register (0x0C for A, 0x10 for B) and sets that half's timeout flag. The flag stays set until a status write with bit 0 (A) or bit 1 (B) set to 1. Writing 0 to that bit leaves the flag unchanged.
- R6: A write to a value register is ignored while that half is in edge-count mode.
- R7: In edge-count mode, each synchronized rising edge of the half's capture input lowers its value by one. Reading the half's reload/capture register returns the number of edges seen since that register was last written.
- R8: In edge-time mode the half keeps counting every clock. On a rising edge of its capture input, the half stores its count from the clock edge where the synchronized edge is detected. That is the count shown two cycles after the input is first sampled high, so a value v read just before the input rises gives a stored value of v-2. The reload/capture register returns the stored value.
- R9: With the 32-bit join set, A's value register reads {B count[15:0], A count[15:0]}. The pair counts as one 32-bit down counter under A's enable and mode. A write to A's value loads all 32 bits, and bits 15:0 of B's value register show the upper half.
- R10: In periodic mode the reload/capture register reads back the half's current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (5) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| cap_a | input | 1 | Capture input of half A, asynchronous |
| cap_b | input | 1 | Capture input of half B, asynchronous |
| tmo_a | output | 1 | Sticky timeout flag of half A |
| tmo_b | output | 1 | Sticky timeout flag of half B |

## Verification
Some behaviours are checked by assertions on every cycle:
- the one-cycle delay between a value write and the load,
- the blocking of writes in edge-count mode,
- the stickiness and clearing of the timeout flag,
- the edge counter stepping once per detected edge,
- the 32-bit decrement with borrow across the halves.

Other behaviours can only be shown by the bench's scenarios: the reset values, the bit layout of each read word, the exact count latched by an asynchronous capture edge after synchronization, and the reload and timeout after a countdown to zero. Random loads and wait times in both the 16-bit and 32-bit arrangements are compared against values the bench computes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      MODE_PERIODIC  = 2'd0,
      MODE_EDGE_CNT  = 2'd1,
      MODE_EDGE_TIME = 2'd2,
      MODE_RSVD      = 2'd3
   } half_mode_e;

   localparam int OFS_CTRL  = 'h00;
   localparam int OFS_VAL_A = 'h04;
   localparam int OFS_VAL_B = 'h08;
   localparam int OFS_REG_A = 'h0C;
   localparam int OFS_REG_B = 'h10;
   localparam int OFS_STAT  = 'h14;

   localparam int CB_EN_A   = 0;
   localparam int CB_EN_B   = 1;
   localparam int CB_WIDE   = 2;
   localparam int CB_MODE_A = 3;
   localparam int CB_MODE_B = 5;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], din};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tmr_half_capture.sv
module tmr_half_capture #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cnt_en,
   input  logic          time_en,
   input  logic          rise,
   input  logic          clr,
   input  logic [CW-1:0] cur_val,
   output logic [CW-1:0] edge_cnt,
   output logic [CW-1:0] cap_val
);
   always_ff @(posedge clk) begin
      if (rst) begin
         edge_cnt <= '0;
         cap_val  <= '0;
      end else begin
         if (clr)                 edge_cnt <= '0;
         else if (rise && cnt_en) edge_cnt <= edge_cnt + 1'b1;
         if (rise && time_en)     cap_val  <= cur_val;
      end
   end
endmodule

// File: rtl/tmr_value_core.sv
module tmr_value_core #(
   parameter int DW    = 32,
   parameter int CNT_W = 16,
   parameter int PRE_W = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wide,
   input  logic          step_a,
   input  logic          step_b,
   input  logic          load_a,
   input  logic          load_b,
   input  logic [DW-1:0] ld_a,
   input  logic [DW-1:0] ld_b,
   input  logic [DW-1:0] rl_a,
   input  logic [DW-1:0] rl_b,
   output logic [PRE_W+CNT_W-1:0] val_a,
   output logic [PRE_W+CNT_W-1:0] val_b,
   output logic          hit_a,
   output logic          hit_b
);
   localparam int HW = PRE_W + CNT_W;
   localparam int WW = 2 * CNT_W;

   logic [WW-1:0] wv, wrl;

   assign wv  = {val_b[CNT_W-1:0], val_a[CNT_W-1:0]};
   assign wrl = {rl_b[CNT_W-1:0], rl_a[CNT_W-1:0]};

   always_comb begin
      if (wide) begin
         hit_a = step_a && !load_a && !load_b && (wv == '0);
         hit_b = 1'b0;
      end else begin
         hit_a = step_a && !load_a && (val_a == '0);
         hit_b = step_b && !load_b && (val_b == '0);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         val_a <= '1;
         val_b <= '1;
      end else if (wide) begin
         if (load_a) begin
            val_a[CNT_W-1:0] <= ld_a[CNT_W-1:0];
            val_b[CNT_W-1:0] <= ld_a[WW-1:CNT_W];
         end else if (load_b) begin
            val_b <= ld_b[HW-1:0];
         end else if (step_a) begin
            {val_b[CNT_W-1:0], val_a[CNT_W-1:0]} <= hit_a ? wrl : wv - 1'b1;
         end
      end else begin
         if (load_a)      val_a <= ld_a[HW-1:0];
         else if (step_a) val_a <= hit_a ? rl_a[HW-1:0] : val_a - 1'b1;
         if (load_b)      val_b <= ld_b[HW-1:0];
         else if (step_b) val_b <= hit_b ? rl_b[HW-1:0] : val_b - 1'b1;
      end
   end
endmodule

// File: rtl/tmr_dual_value.sv
module tmr_dual_value
   import tmr_pkg::*;
#(
   parameter int DW          = 32,
   parameter int AW          = 5,
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          cap_a,
   input  logic          cap_b,
   output logic          tmo_a,
   output logic          tmo_b
);
   localparam int HW = PRE_W + CNT_W;
   localparam int WW = 2 * CNT_W;

   generate
      if (HW > DW) begin : g_chk_hw
         $error("prescaler plus counter exceeds the data width");
      end
      if (WW > DW) begin : g_chk_ww
         $error("joined counter exceeds the data width");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("at least two synchronizer stages are required");
      end
      if (AW < 5) begin : g_chk_aw
         $error("address width too small for the register map");
      end
   endgenerate

   logic          cfg_wide;
   logic [1:0]    cfg_en;
   half_mode_e    mode_a, mode_b;
   logic [DW-1:0] rl_a, rl_b;
   logic [1:0]    pend;
   logic [DW-1:0] pend_a, pend_b;
   logic          load_a, load_b, step_a, step_b, hit_a, hit_b;
   logic [HW-1:0] val_a, val_b;
   logic [1:0]    rise, wr_reg;
   logic [1:0]    cap_in;
   logic [DW-1:0] ecnt [2];
   logic [DW-1:0] capv [2];
   logic [DW-1:0] curv [2];
   half_mode_e    hmode [2];
   logic [DW-1:0] rd_val_a, rd_val_b;
   logic          wr_ctrl, wr_val_a, wr_val_b, wr_stat, ok_a, ok_b;

   assign wr_ctrl   = bus_wr && (bus_addr == AW'(OFS_CTRL));
   assign wr_val_a  = bus_wr && (bus_addr == AW'(OFS_VAL_A));
   assign wr_val_b  = bus_wr && (bus_addr == AW'(OFS_VAL_B));
   assign wr_reg[0] = bus_wr && (bus_addr == AW'(OFS_REG_A));
   assign wr_reg[1] = bus_wr && (bus_addr == AW'(OFS_REG_B));
   assign wr_stat   = bus_wr && (bus_addr == AW'(OFS_STAT));
   assign ok_a      = wr_val_a && (mode_a != MODE_EDGE_CNT);
   assign ok_b      = wr_val_b && (mode_b != MODE_EDGE_CNT);

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_wide <= 1'b0;
         cfg_en   <= '0;
         mode_a   <= MODE_PERIODIC;
         mode_b   <= MODE_PERIODIC;
         rl_a     <= '1;
         rl_b     <= '1;
         pend     <= '0;
         pend_a   <= '0;
         pend_b   <= '0;
         tmo_a    <= 1'b0;
         tmo_b    <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            cfg_en   <= {bus_wdata[CB_EN_B], bus_wdata[CB_EN_A]};
            cfg_wide <= bus_wdata[CB_WIDE];
            mode_a   <= half_mode_e'(bus_wdata[CB_MODE_A+:2]);
            mode_b   <= half_mode_e'(bus_wdata[CB_MODE_B+:2]);
         end
         if (wr_reg[0]) rl_a <= bus_wdata;
         if (wr_reg[1]) rl_b <= bus_wdata;
         pend <= {ok_b, ok_a};
         if (ok_a) pend_a <= bus_wdata;
         if (ok_b) pend_b <= bus_wdata;
         tmo_a <= hit_a | (tmo_a & ~(wr_stat & bus_wdata[0]));
         tmo_b <= hit_b | (tmo_b & ~(wr_stat & bus_wdata[1]));
      end
   end

   assign load_a = pend[0];
   assign load_b = pend[1];

   always_comb begin
      step_a = cfg_en[0] && ((mode_a == MODE_EDGE_CNT) ? rise[0] : 1'b1);
      step_b = !cfg_wide && cfg_en[1] && ((mode_b == MODE_EDGE_CNT) ? rise[1] : 1'b1);
   end

   tmr_value_core #(.DW(DW), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
      .clk(clk), .rst(rst), .wide(cfg_wide),
      .step_a(step_a), .step_b(step_b), .load_a(load_a), .load_b(load_b),
      .ld_a(pend_a), .ld_b(pend_b), .rl_a(rl_a), .rl_b(rl_b),
      .val_a(val_a), .val_b(val_b), .hit_a(hit_a), .hit_b(hit_b)
   );

   assign rd_val_a = cfg_wide ? DW'({val_b[CNT_W-1:0], val_a[CNT_W-1:0]}) : DW'(val_a);
   assign rd_val_b = DW'(val_b);
   assign curv[0]  = rd_val_a;
   assign curv[1]  = rd_val_b;
   assign hmode[0] = mode_a;
   assign hmode[1] = cfg_wide ? MODE_PERIODIC : mode_b;
   assign cap_in   = {cap_b, cap_a};

   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .din(cap_in[h]), .rise(rise[h])
         );
         tmr_half_capture #(.CW(DW)) u_cap (
            .clk(clk), .rst(rst),
            .cnt_en(cfg_en[h] && (hmode[h] == MODE_EDGE_CNT)),
            .time_en(cfg_en[h] && (hmode[h] == MODE_EDGE_TIME)),
            .rise(rise[h]), .clr(wr_reg[h]), .cur_val(curv[h]),
            .edge_cnt(ecnt[h]), .cap_val(capv[h])
         );
      end
   endgenerate

   function automatic logic [DW-1:0] reg_view(half_mode_e m, logic [DW-1:0] cur,
                                             logic [DW-1:0] ec, logic [DW-1:0] cp);
      case (m)
         MODE_EDGE_CNT:  return ec;
         MODE_EDGE_TIME: return cp;
         default:        return cur;
      endcase
   endfunction

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         AW'(OFS_CTRL):  bus_rdata = DW'({mode_b, mode_a, cfg_wide, cfg_en});
         AW'(OFS_VAL_A): bus_rdata = rd_val_a;
         AW'(OFS_VAL_B): bus_rdata = rd_val_b;
         AW'(OFS_REG_A): bus_rdata = reg_view(hmode[0], rd_val_a, ecnt[0], capv[0]);
         AW'(OFS_REG_B): bus_rdata = reg_view(hmode[1], rd_val_b, ecnt[1], capv[1]);
         AW'(OFS_STAT):  bus_rdata = DW'({tmo_b, tmo_a});
         default:        bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmr_dual_value_chk.sv
module tmr_dual_value_chk
   import tmr_pkg::*;
#(
   parameter int DW    = 32,
   parameter int AW    = 5,
   parameter int CNT_W = 16,
   parameter int HW    = 24
) (
   input logic          clk,
   input logic          rst,
   input logic          bus_wr,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic          tmo_a,
   input logic          wide,
   input logic          en_a,
   input half_mode_e    mode_a,
   input logic          rise_a,
   input logic          hit_a,
   input logic          load_a,
   input logic          load_b,
   input logic [HW-1:0] val_a,
   input logic [HW-1:0] val_b,
   input logic [DW-1:0] ecnt_a
);
   logic          w_val_a, w_reg_a, w_stat;
   logic [2*CNT_W-1:0] wv;

   assign w_val_a = bus_wr && (bus_addr == AW'(OFS_VAL_A));
   assign w_reg_a = bus_wr && (bus_addr == AW'(OFS_REG_A));
   assign w_stat  = bus_wr && (bus_addr == AW'(OFS_STAT));
   assign wv      = {val_b[CNT_W-1:0], val_a[CNT_W-1:0]};

   a_r3_load_next: assert property (@(posedge clk) disable iff (rst)
      (w_val_a && mode_a != MODE_EDGE_CNT && !wide) ##1 !bus_wr
      |=> val_a == $past(bus_wdata[HW-1:0], 2));

   a_r6_count_write_blocked: assert property (@(posedge clk) disable iff (rst)
      (w_val_a && mode_a == MODE_EDGE_CNT) |=> !load_a);

   a_r5_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
      (tmo_a && !(w_stat && bus_wdata[0])) |=> tmo_a);

   a_r5_timeout_clear: assert property (@(posedge clk) disable iff (rst)
      (w_stat && bus_wdata[0] && !hit_a) |=> !tmo_a);

   a_r7_edge_step: assert property (@(posedge clk) disable iff (rst)
      (en_a && mode_a == MODE_EDGE_CNT && rise_a && !w_reg_a)
      |=> ecnt_a == $past(ecnt_a) + 1'b1);

   a_r9_wide_decrement: assert property (@(posedge clk) disable iff (rst)
      (wide && en_a && mode_a == MODE_PERIODIC && !load_a && !load_b && wv != '0)
      |=> wv == $past(wv) - 1'b1);
endmodule

bind tmr_dual_value tmr_dual_value_chk #(
   .DW(DW), .AW(AW), .CNT_W(CNT_W), .HW(PRE_W + CNT_W)
) u_chk (
   .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .tmo_a(tmo_a), .wide(cfg_wide), .en_a(cfg_en[0]),
   .mode_a(mode_a), .rise_a(rise[0]), .hit_a(hit_a), .load_a(load_a),
   .load_b(load_b), .val_a(val_a), .val_b(val_b), .ecnt_a(ecnt[0])
);

// File: tb/tmr_dual_value_test.sv
module tmr_dual_value_test;
   localparam int DW = 32;
   localparam int AW = 5;
   localparam logic [AW-1:0] A_CTRL = 5'h00, A_VA = 5'h04, A_VB = 5'h08,
                             A_RA = 5'h0C, A_RB = 5'h10, A_ST = 5'h14;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          cap_a = 1'b0, cap_b = 1'b0;
   logic          tmo_a, tmo_b;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   tmr_dual_value uut (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_a(cap_a),
      .cap_b(cap_b), .tmo_a(tmo_a), .tmo_b(tmo_b)
   );

   function automatic logic [31:0] down24(logic [31:0] s, int m);
      return (s - 32'(m)) & 32'h00FF_FFFF;
   endfunction

   function automatic logic [31:0] down32(logic [31:0] s, int m);
      return s - 32'(m);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20ns * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v, v2, d, k;
      int unsigned seed;
      seed = $urandom(32'h5EED_0042);
      idle(3);
      rst = 1'b0;
      idle(1);

      // R1 reset state
      rd(A_VA, v); check("R1 A value", v, 32'h00FF_FFFF);
      rd(A_VB, v); check("R1 B value", v, 32'h00FF_FFFF);
      check("R1 tmo_a", 32'(tmo_a), 0);
      check("R1 tmo_b", 32'(tmo_b), 0);
      wr(A_CTRL, 32'h04);
      rd(A_VA, v); check("R1 joined value", v, 32'hFFFF_FFFF);
      wr(A_CTRL, 32'h00);

      // R4 disabled halves hold
      idle(5);
      rd(A_VA, v); check("R4 disabled hold", v, 32'h00FF_FFFF);

      // R3 one-cycle load delay, R2 borrow into prescaler
      wr(A_CTRL, 32'h03);
      wr(A_VA, 32'h0001_0002);
      rd(A_VA, v); check("R3 old value still shown", 32'(v == 32'h0001_0002), 0);
      idle(1);
      rd(A_VA, v); check("R3 loaded value", v, 32'h0001_0002);
      idle(3);
      rd(A_VA, v); check("R2 borrow into prescaler", v, 32'h0000_FFFF);

      // R10 periodic reload/capture register mirrors value
      rd(A_VA, v); rd(A_RA, v2); check("R10 reg reads value", v2, v);

      // R5 timeout on A
      wr(A_RA, 32'h0000_0100);
      wr(A_VA, 32'd3);
      idle(1);
      rd(A_VA, v); check("R5 load 3", v, 3);
      idle(3);
      rd(A_VA, v); check("R5 at zero", v, 0);
      check("R5 no flag yet", 32'(tmo_a), 0);
      idle(1);
      rd(A_VA, v); check("R5 reload", v, 32'h100);
      check("R5 flag set", 32'(tmo_a), 1);
      idle(2);
      check("R5 flag sticky", 32'(tmo_a), 1);
      wr(A_ST, 32'h0);
      check("R5 write 0 keeps flag", 32'(tmo_a), 1);
      wr(A_ST, 32'h1);
      check("R5 write 1 clears A", 32'(tmo_a), 0);

      // R5 timeout on B, status bit 1
      wr(A_RB, 32'h0000_0050);
      wr(A_VB, 32'd1);
      idle(1);
      rd(A_VB, v); check("R5 B load", v, 1);
      idle(2);
      rd(A_VB, v); check("R5 B reload", v, 32'h50);
      check("R5 B flag", 32'(tmo_b), 1);
      wr(A_ST, 32'h2);
      check("R5 B cleared", 32'(tmo_b), 0);

      // R4 random loads and waits, 16-bit halves
      for (int i = 0; i < 20; i++) begin
         logic [AW-1:0] a;
         int m;
         a = ($urandom % 2) ? A_VB : A_VA;
         d = 32'(1000 + ($urandom % (32'h0100_0000 - 1000)));
         m = int'($urandom % 300);
         wr(a, d);
         idle(1 + m);
         rd(a, v); check("R4 random countdown", v, down24(d, m));
         check("R2 upper byte zero", v & 32'hFF00_0000, 0);
      end

      // R6 value write ignored in edge-count mode
      wr(A_CTRL, 32'h0B);
      idle(2);
      rd(A_VA, v);
      wr(A_VA, 32'h0000_1234);
      idle(2);
      rd(A_VA, v2); check("R6 write ignored", v2, v);

      // R7 edge counting
      wr(A_RA, 32'h100);
      rd(A_VA, v);
      k = 32'(3 + ($urandom % 7));
      for (int e = 0; e < int'(k); e++) begin
         @(negedge clk); cap_a = 1'b1;
         idle(3); cap_a = 1'b0;
         idle(3);
      end
      idle(4);
      rd(A_RA, v2); check("R7 edge total", v2, k);
      rd(A_VA, v2); check("R7 value stepped per edge", v2, down24(v, int'(k)));

      // R8 edge-time capture on B
      wr(A_CTRL, 32'h43);
      for (int c = 0; c < 3; c++) begin
         idle(2 + int'($urandom % 20));
         @(negedge clk);
         rd(A_VB, v);
         cap_b = 1'b1;
         idle(5);
         cap_b = 1'b0;
         idle(3);
         rd(A_RB, v2); check("R8 captured count", v2, down24(v, 2));
      end

      // R9 joined 32-bit counter
      wr(A_CTRL, 32'h05);
      wr(A_VA, 32'h0002_0001);
      idle(1);
      rd(A_VA, v); check("R9 joined load", v, 32'h0002_0001);
      rd(A_VB, v); check("R9 B shows upper half", v & 32'h0000_FFFF, 32'h0002);
      idle(2);
      rd(A_VA, v); check("R9 borrow across halves", v, 32'h0001_FFFF);
      for (int i = 0; i < 10; i++) begin
         int m;
         d = 1000 + $urandom % 32'hFFFF_F000;
         m = int'($urandom % 300);
         wr(A_VA, d);
         idle(1 + m);
         rd(A_VA, v); check("R9 random joined countdown", v, down32(d, m));
      end

      finish_run();
   end
endmodule